// File: doc/BRIEF.md
# Don't-Care Count Pattern Partitioner

This block receives a set of ternary test patterns, one per input beat, and sorts them into two groups by how many unspecified symbols each holds. During the load pass every accepted pattern is written into an internal buffer together with its count of X symbols, and a running minimum of those counts is kept. The data itself sets the split point: the threshold is the smallest X count found in the whole set.

Once the beat flagged as last has been taken in, the block switches to the replay pass. It presents the stored patterns again in arrival order on a valid/ready output, each with its X count and a one-bit group tag. Patterns whose count matches the threshold exactly go to the specified-heavy group (tag 0). All others go to the don't-care-heavy group (tag 1). A later stage that merges each group's patterns consumes this stream.

The controller has two named states. ST_LOAD accepts input and moves to ST_EMIT when the last beat is taken. ST_EMIT drives the output stream and returns to ST_LOAD on the handshake of the final stored pattern. A one-cycle pulse marks the end of each pass.

Top module: `dcp_partitioner`

## Requirements
- R1: Each pattern holds PAT_LEN 2-bit symbols, symbol i at bits [2i+1:2i], encoded 2'b00 = 0, 2'b01 = 1, 2'b10 = X. out_xcnt is the number of symbols equal to 2'b10. The unused code 2'b11 does not count as X.
- R2: The threshold takes the X count of the first stored pattern. A later stored pattern replaces it only if its count is strictly smaller. The threshold is therefore the minimum over all stored patterns of the set.
- R3: During replay, out_tag is 0 (specified-heavy group) when out_xcnt equals the threshold and 1 (don't-care-heavy group) otherwise.
- R4: Replay presents every stored pattern exactly once, in load order. out_last is high only with the final stored pattern.
- R5: in_ready is high in ST_LOAD and low throughout ST_EMIT. Replay begins only after the beat carrying in_last has been accepted.
- R6: load_done is a one-cycle pulse in the cycle after the in_last beat is accepted. out_valid first rises in that same cycle.
- R7: replay_done is a one-cycle pulse in the cycle after the last stored pattern is handshaken. In that cycle out_valid is low and in_ready is high.
- R8: A beat that arrives when DEPTH patterns are already stored is dropped, and overflow goes high. overflow stays high through replay and clears when ST_EMIT is left. A dropped beat that carries in_last still ends the load pass.
- R9: While out_valid is high and out_ready is low, out_sym, out_xcnt, out_tag and out_last hold their values.
- R10: After reset, in_ready is high and out_valid, load_done, replay_done and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pattern present |
| in_ready | output | 1 | Block accepts input (load pass) |
| in_sym | input | 2*PAT_LEN | Input pattern symbols |
| in_last | input | 1 | Marks the final pattern of the set |
| out_valid | output | 1 | Replayed pattern present |
| out_ready | input | 1 | Consumer takes the replayed pattern |
| out_sym | output | 2*PAT_LEN | Replayed pattern symbols |
| out_xcnt | output | CW | X count of the replayed pattern |
| out_tag | output | 1 | 0 = specified-heavy group, 1 = don't-care-heavy group |
| out_last | output | 1 | Final stored pattern of the set |
| load_done | output | 1 | End-of-load pulse |
| replay_done | output | 1 | End-of-replay pulse |
| overflow | output | 1 | A beat was dropped because the buffer was full |

## Verification
The assertions assume three things about the environment. Each set is closed by an in_last beat. The input side does not expect beats to be taken while in_ready is low. The consumer may stall the output at any cycle. The stimulus meets these assumptions: it drives beats only in the load pass, always ends a set with in_last, and inserts random idle cycles on the input and random stalls on out_ready. Symbols are drawn from all four codes so the unused code is exercised. The directed sets force the remaining corners: the minimum arriving late, ties, a single-pattern set, all-X patterns, an exactly full buffer and an overfull one.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
    typedef logic [1:0] sym_t;
    localparam sym_t SYM_ZERO = 2'b00;
    localparam sym_t SYM_ONE  = 2'b01;
    localparam sym_t SYM_DC   = 2'b10;
    typedef enum logic {ST_LOAD, ST_EMIT} dcp_state_t;
endpackage

// File: rtl/dcp_xcount.sv
module dcp_xcount
    import dcp_pkg::*;
#(
    parameter int PAT_LEN = 8,
    localparam int CW     = $clog2(PAT_LEN + 1)
) (
    input  logic [2*PAT_LEN-1:0] pat,
    output logic [CW-1:0]        xcnt
);
    logic [PAT_LEN-1:0] is_dc;

    for (genvar g = 0; g < PAT_LEN; g++) begin : g_sym
        assign is_dc[g] = (pat[2*g +: 2] == SYM_DC);
    end

    always_comb begin
        xcnt = '0;
        for (int i = 0; i < PAT_LEN; i++) begin
            xcnt = xcnt + CW'(is_dc[i]);
        end
    end
endmodule

// File: rtl/dcp_store.sv
module dcp_store #(
    parameter int PAT_LEN = 8,
    parameter int DEPTH   = 16,
    parameter int CW      = 4,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [2*PAT_LEN-1:0] wpat,
    input  logic [CW-1:0]        wcnt,
    input  logic [AW-1:0]        raddr,
    output logic [2*PAT_LEN-1:0] rpat,
    output logic [CW-1:0]        rcnt
);
    logic [2*PAT_LEN-1:0] pat_mem [DEPTH];
    logic [CW-1:0]        cnt_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            pat_mem[waddr] <= wpat;
            cnt_mem[waddr] <= wcnt;
        end
    end

    assign rpat = pat_mem[raddr];
    assign rcnt = cnt_mem[raddr];
endmodule

// File: rtl/dcp_min_track.sv
module dcp_min_track #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          first,
    input  logic [CW-1:0] val,
    output logic [CW-1:0] min_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= '0;
        end else if (upd && (first || (val < min_q))) begin
            min_q <= val;
        end
    end
endmodule

// File: rtl/dcp_partitioner.sv
module dcp_partitioner
    import dcp_pkg::*;
#(
    parameter int PAT_LEN = 8,
    parameter int DEPTH   = 16,
    localparam int CW     = $clog2(PAT_LEN + 1),
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW     = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2*PAT_LEN-1:0] in_sym,
    input  logic                 in_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [2*PAT_LEN-1:0] out_sym,
    output logic [CW-1:0]        out_xcnt,
    output logic                 out_tag,
    output logic                 out_last,
    output logic                 load_done,
    output logic                 replay_done,
    output logic                 overflow
);
    dcp_state_t state_q, state_d;

    logic [NW-1:0] wr_cnt_q;
    logic [NW-1:0] rd_ptr_q;
    logic [CW-1:0] in_xcnt;
    logic [CW-1:0] thresh_q;
    logic          accept, store_en, refuse, fire, leave_emit;

    // Load-side X population count
    dcp_xcount #(.PAT_LEN(PAT_LEN)) u_xcount (
        .pat  (in_sym),
        .xcnt (in_xcnt)
    );

    assign accept     = (state_q == ST_LOAD) && in_valid;
    assign store_en   = accept && (wr_cnt_q < NW'(DEPTH));
    assign refuse     = accept && !(wr_cnt_q < NW'(DEPTH));
    assign fire       = out_valid && out_ready;
    assign leave_emit = fire && out_last;

    dcp_store #(.PAT_LEN(PAT_LEN), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk   (clk),
        .we    (store_en),
        .waddr (wr_cnt_q[AW-1:0]),
        .wpat  (in_sym),
        .wcnt  (in_xcnt),
        .raddr (rd_ptr_q[AW-1:0]),
        .rpat  (out_sym),
        .rcnt  (out_xcnt)
    );

    dcp_min_track #(.CW(CW)) u_min (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (store_en),
        .first (wr_cnt_q == '0),
        .val   (in_xcnt),
        .min_q (thresh_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Transitions: LOAD->EMIT on accepted last beat, EMIT->LOAD on final handshake
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: if (accept && in_last) state_d = ST_EMIT;
            ST_EMIT: if (leave_emit)        state_d = ST_LOAD;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_LOAD: in_ready  = 1'b1;
            ST_EMIT: out_valid = 1'b1;
        endcase
    end

    assign out_last = (rd_ptr_q == wr_cnt_q - NW'(1));
    assign out_tag  = (out_xcnt != thresh_q);

    // Counters, flag and pass-end pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt_q    <= '0;
            rd_ptr_q    <= '0;
            overflow    <= 1'b0;
            load_done   <= 1'b0;
            replay_done <= 1'b0;
        end else begin
            load_done   <= accept && in_last;
            replay_done <= leave_emit;
            if (leave_emit) begin
                wr_cnt_q <= '0;
                rd_ptr_q <= '0;
                overflow <= 1'b0;
            end else begin
                if (store_en) wr_cnt_q <= wr_cnt_q + NW'(1);
                if (fire)     rd_ptr_q <= rd_ptr_q + NW'(1);
                if (refuse)   overflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dcp_partitioner_chk.sv
module dcp_partitioner_chk #(
    parameter int PAT_LEN = 8,
    parameter int CW      = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 in_last,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [2*PAT_LEN-1:0] out_sym,
    input logic [CW-1:0]        out_xcnt,
    input logic                 out_tag,
    input logic                 out_last,
    input logic                 load_done,
    input logic                 replay_done,
    input logic                 overflow,
    input logic [CW-1:0]        thresh
);
    // R5: input and output sides are never open together
    a_r5_exclusive_sides: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R5: replay starts only after an accepted last beat
    a_r5_replay_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_last));

    // R6: end-of-load pulse is one cycle and coincides with output start
    a_r6_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (out_valid && $rose(out_valid)) ##1 !load_done);

    // R7: end-of-replay pulse follows the final handshake
    a_r7_replay_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        replay_done |-> (in_ready && !out_valid && $past(out_valid && out_ready && out_last)));

    // R2/R3: the threshold never exceeds a replayed count, so tag 0 means the minimum
    a_r2_thresh_is_min: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_xcnt >= thresh));

    // R9: output held under backpressure
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_xcnt)
                                       && $stable(out_tag) && $stable(out_last)));

    // R8: overflow rises only from an input beat and persists through replay
    a_r8_overflow_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(in_valid && in_ready));
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(out_valid && out_ready && out_last)) |=> overflow);
endmodule

bind dcp_partitioner dcp_partitioner_chk #(.PAT_LEN(PAT_LEN), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_last     (in_last),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_sym     (out_sym),
    .out_xcnt    (out_xcnt),
    .out_tag     (out_tag),
    .out_last    (out_last),
    .load_done   (load_done),
    .replay_done (replay_done),
    .overflow    (overflow),
    .thresh      (thresh_q)
);

// File: tb/dcp_partitioner_test.sv
module dcp_partitioner_test;
    localparam int PAT_LEN = 8;
    localparam int DEPTH   = 16;
    localparam int CW      = $clog2(PAT_LEN + 1);
    localparam int MAXP    = DEPTH + 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [2*PAT_LEN-1:0] in_sym = '0;
    logic                 in_last = 1'b0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic [2*PAT_LEN-1:0] out_sym;
    logic [CW-1:0]        out_xcnt;
    logic                 out_tag;
    logic                 out_last;
    logic                 load_done;
    logic                 replay_done;
    logic                 overflow;

    int checks = 0;
    int failures = 0;
    logic [2*PAT_LEN-1:0] pats [MAXP];

    always #10 clk = ~clk;

    dcp_partitioner #(.PAT_LEN(PAT_LEN), .DEPTH(DEPTH)) uut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: count symbols equal to 2'b10
    function automatic int f_xcnt(input logic [2*PAT_LEN-1:0] p);
        int n = 0;
        for (int i = 0; i < PAT_LEN; i++) if (p[2*i +: 2] == 2'b10) n++;
        return n;
    endfunction

    function automatic logic [2*PAT_LEN-1:0] mk_pat(input int nx);
        logic [2*PAT_LEN-1:0] p;
        for (int i = 0; i < PAT_LEN; i++)
            p[2*i +: 2] = (i < nx) ? 2'b10 : {1'b0, 1'($urandom % 2)};
        return p;
    endfunction

    function automatic logic [2*PAT_LEN-1:0] rnd_pat();
        logic [2*PAT_LEN-1:0] p;
        for (int i = 0; i < PAT_LEN; i++) p[2*i +: 2] = 2'($urandom % 4);
        return p;
    endfunction

    task automatic run_set(input int n, input int gap);
        int stored = (n < DEPTH) ? n : DEPTH;
        int exp_min = f_xcnt(pats[0]);
        int j = 0;
        int cyc = 0;
        for (int i = 1; i < stored; i++) if (f_xcnt(pats[i]) < exp_min) exp_min = f_xcnt(pats[i]);
        for (int i = 0; i < n; i++) begin
            while (($urandom % 100) < gap) begin
                @(negedge clk); in_valid = 1'b0;
                chk(out_valid == 1'b0, "R5 no replay before last", out_valid, 0);
                @(posedge clk);
            end
            @(negedge clk);
            chk(in_ready == 1'b1, "R5 ready in load", in_ready, 1);
            in_valid = 1'b1; in_sym = pats[i]; in_last = (i == n - 1);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk(load_done == 1'b1, "R6 load_done pulse", load_done, 1);
        chk(in_ready == 1'b0, "R5 ready low in replay", in_ready, 0);
        chk(overflow == (n > DEPTH), "R8 overflow flag", overflow, n > DEPTH);
        while (j < stored) begin
            bit rdy = ($urandom % 4) != 0;
            out_ready = rdy;
            chk(out_valid == 1'b1, "R6 out_valid in replay", out_valid, 1);
            chk(out_sym == pats[j], "R4 order", out_sym, pats[j]);
            chk(int'(out_xcnt) == f_xcnt(pats[j]), "R1 xcount", out_xcnt, f_xcnt(pats[j]));
            chk(out_tag == (f_xcnt(pats[j]) != exp_min), "R3 tag vs R2 threshold",
                out_tag, f_xcnt(pats[j]) != exp_min);
            chk(out_last == (j == stored - 1), "R4 last marker", out_last, j == stored - 1);
            if (cyc > 0) chk(load_done == 1'b0, "R6 pulse width", load_done, 0);
            if (n > DEPTH) chk(overflow == 1'b1, "R8 overflow held", overflow, 1);
            cyc++;
            @(posedge clk);
            if (rdy) j++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(replay_done == 1'b1, "R7 replay_done pulse", replay_done, 1);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R7 back to load", {in_ready, out_valid}, 2);
        chk(overflow == 1'b0, "R8 overflow cleared", overflow, 0);
        @(posedge clk); @(negedge clk);
        chk(replay_done == 1'b0, "R7 pulse width", replay_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R10 reset in_ready", in_ready, 1);
        chk({out_valid, load_done, replay_done, overflow} == 4'b0, "R10 reset flags",
            {out_valid, load_done, replay_done, overflow}, 0);
        rst_n = 1'b1;

        // single pattern: it is its own minimum
        pats[0] = mk_pat(3);
        run_set(1, 0);
        // R2 strict replacement: minimum arrives late, ties with it
        pats[0] = mk_pat(6); pats[1] = mk_pat(4); pats[2] = mk_pat(2);
        pats[3] = mk_pat(5); pats[4] = mk_pat(2);
        run_set(5, 20);
        // all equal counts: all in group 0
        for (int i = 0; i < 4; i++) pats[i] = mk_pat(3);
        run_set(4, 0);
        // all-X and no-X mix, unused code 2'b11
        pats[0] = {PAT_LEN{2'b10}}; pats[1] = {PAT_LEN{2'b11}}; pats[2] = mk_pat(PAT_LEN);
        run_set(3, 0);
        // exactly full buffer
        for (int i = 0; i < DEPTH; i++) pats[i] = rnd_pat();
        run_set(DEPTH, 10);
        // overfull: R8 beats dropped, last still ends load
        for (int i = 0; i < DEPTH + 3; i++) pats[i] = (i >= DEPTH) ? mk_pat(0) : mk_pat(1 + i % 4);
        run_set(DEPTH + 3, 0);
        // random sets
        for (int s = 0; s < 25; s++) begin
            int n = 1 + int'($urandom % DEPTH);
            for (int i = 0; i < n; i++) pats[i] = rnd_pat();
            run_set(n, 30);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule